// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts where a procedure return will go in an instruction fetch front end. Targets of returns are poorly served by a table indexed by the fetch PC, because a single return instruction goes back to whichever site called the procedure. Calls and returns nest, so a small last-in first-out store of return addresses gives a much better guess.

When the fetch logic marks the current fetch as a call, the block stores the address of the instruction after the call: the call's PC plus its length, which is 4 bytes or 2 bytes. When the fetch is marked as a return, the block removes the newest stored address and presents it as the predicted next PC for that same cycle. The stack holds `DEPTH` entries (default 8). Deeper nesting silently replaces the oldest entry. Which fetches are calls or returns is decided upstream. Repairing the stack after a wrong-path fetch is not part of this block.

Events arrive as plain per-cycle flags. The stack accepts every event in the cycle it is presented and never applies back-pressure, so there is no ready signal. The prediction is valid only in the cycle that carries the return flag.

Top module: `ras_predictor`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties the stack. A return fetched after reset gives `pred_valid` = 0.
- R2: A call pushes `fetch_pc + 4` when `half_len` = 0, and `fetch_pc + 2` when `half_len` = 1.
- R3: A return presents the most recently pushed entry that is still stored, on `pred_target` with `pred_valid` = 1, in the same cycle. It then removes that entry, so entries come back newest first.
- R4: A return on an empty stack gives `pred_valid` = 0 and leaves the stack unchanged. A later push followed by a pop returns that pushed value.
- R5: A push onto a full stack succeeds and replaces the oldest entry. After more than `DEPTH` pushes, exactly the newest `DEPTH` addresses can be popped, newest first, and a further pop is invalid.
- R6: When call and return are both asserted in one cycle, the pop happens first: the prediction is the old top. The call's return address then takes its place, and the number of entries is unchanged. On an empty stack, the prediction is invalid and the stack then holds one entry.
- R7: `pred_valid` is 0 in every cycle where `is_ret` is 0.
- R8: The return-address sum wraps modulo 2^`AW`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; empties the stack |
| fetch_pc | input | AW | PC of the fetched instruction |
| is_call | input | 1 | Fetch is a procedure call: push its return address |
| is_ret | input | 1 | Fetch is a procedure return: pop and predict |
| half_len | input | 1 | 1 = 2-byte instruction, 0 = 4-byte instruction |
| pred_target | output | AW | Predicted return target (zero when not valid) |
| pred_valid | output | 1 | Prediction valid; only possible while `is_ret` is 1 |

## Verification
The hardest case to reach from the ports is the wrapped full stack. The write index must have gone all the way around and overwritten the oldest slot, and draining it must still stop exactly at the empty boundary rather than returning stale entries. The bench pushes `DEPTH + 2` distinct addresses, then pops `DEPTH + 1` times. It expects the newest `DEPTH` addresses in reverse order followed by one invalid pop. A second hard case is a combined call and return, on both a non-empty and an empty stack. Each is followed by pops that show which entry was replaced and that the depth did not change.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic {
    LEN_FULL = 1'b0,
    LEN_HALF = 1'b1
  } len_e;

  function automatic int idx_width(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/ras_addr_gen.sv
module ras_addr_gen #(
  parameter int AW         = 32,
  parameter int FULL_BYTES = 4,
  parameter int HALF_BYTES = 2
) (
  input  logic [AW-1:0] pc,
  input  logic          half_len,
  output logic [AW-1:0] ret_addr
);
  import ras_pkg::*;

  len_e            len_kind;
  logic [AW-1:0]   step;

  always_comb begin
    len_kind = len_e'(half_len);
    step     = (len_kind == LEN_HALF) ? AW'(HALF_BYTES) : AW'(FULL_BYTES);
    ret_addr = pc + step;
  end
endmodule

// File: rtl/ras_ptr.sv
module ras_ptr #(
  parameter int DEPTH = 8
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  pop_req,
  input  logic                                  push_req,
  output logic                                  pop_ok,
  output logic [ras_pkg::idx_width(DEPTH)-1:0]  rd_idx,
  output logic                                  wr_en,
  output logic [ras_pkg::idx_width(DEPTH)-1:0]  wr_idx
);
  localparam int PW   = ras_pkg::idx_width(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int LAST = DEPTH - 1;

  logic [PW-1:0] top_q, top_d, top_after_pop;
  logic [CW-1:0] cnt_q, cnt_d, cnt_after_pop;

  function automatic logic [PW-1:0] step_up(input logic [PW-1:0] i);
    return (i == PW'(LAST)) ? '0 : i + PW'(1);
  endfunction

  function automatic logic [PW-1:0] step_down(input logic [PW-1:0] i);
    return (i == '0) ? PW'(LAST) : i - PW'(1);
  endfunction

  always_comb begin
    pop_ok        = pop_req && (cnt_q != '0);
    top_after_pop = pop_ok ? step_down(top_q) : top_q;
    cnt_after_pop = pop_ok ? cnt_q - CW'(1) : cnt_q;
    wr_en         = push_req;
    wr_idx        = step_up(top_after_pop);
    if (push_req) begin
      top_d = wr_idx;
      cnt_d = (cnt_after_pop == CW'(DEPTH)) ? cnt_after_pop : cnt_after_pop + CW'(1);
    end else begin
      top_d = top_after_pop;
      cnt_d = cnt_after_pop;
    end
  end

  assign rd_idx = top_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q <= PW'(LAST);
      cnt_q <= '0;
    end else begin
      top_q <= top_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int AW    = 32,
  parameter int DEPTH = 8
) (
  input  logic                                 clk,
  input  logic                                 wr_en,
  input  logic [ras_pkg::idx_width(DEPTH)-1:0] wr_idx,
  input  logic [AW-1:0]                        wr_data,
  input  logic [ras_pkg::idx_width(DEPTH)-1:0] rd_idx,
  output logic [AW-1:0]                        rd_data
);
  localparam int PW = ras_pkg::idx_width(DEPTH);

  logic [AW-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [AW-1:0] val_q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == PW'(g))) val_q <= wr_data;
    end
    assign slot[g] = val_q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == PW'(i)) rd_data = slot[i];
    end
  end
endmodule

// File: rtl/ras_predictor.sv
module ras_predictor #(
  parameter int AW         = 32,
  parameter int DEPTH      = 8,
  parameter int FULL_BYTES = 4,
  parameter int HALF_BYTES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] fetch_pc,
  input  logic          is_call,
  input  logic          is_ret,
  input  logic          half_len,
  output logic [AW-1:0] pred_target,
  output logic          pred_valid
);
  localparam int PW = ras_pkg::idx_width(DEPTH);

  logic [AW-1:0] ret_addr;
  logic [AW-1:0] top_data;
  logic [PW-1:0] rd_idx, wr_idx;
  logic          wr_en, pop_ok;

  ras_addr_gen #(
    .AW(AW), .FULL_BYTES(FULL_BYTES), .HALF_BYTES(HALF_BYTES)
  ) u_addr (
    .pc(fetch_pc), .half_len(half_len), .ret_addr(ret_addr)
  );

  ras_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst(rst),
    .pop_req(is_ret), .push_req(is_call),
    .pop_ok(pop_ok), .rd_idx(rd_idx),
    .wr_en(wr_en), .wr_idx(wr_idx)
  );

  ras_store #(.AW(AW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(ret_addr),
    .rd_idx(rd_idx), .rd_data(top_data)
  );

  assign pred_valid  = pop_ok;
  assign pred_target = pop_ok ? top_data : '0;
endmodule

// File: rtl/ras_predictor_chk.sv
module ras_predictor_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] fetch_pc,
  input logic          is_call,
  input logic          is_ret,
  input logic          half_len,
  input logic [AW-1:0] pred_target,
  input logic          pred_valid
);
  logic [AW-1:0] exp_ret;
  assign exp_ret = fetch_pc + (half_len ? AW'(2) : AW'(4));

  // R1: right after reset a return finds nothing
  p_reset_empty_r1: assert property (@(posedge clk)
    ($past(rst) && is_ret) |-> !pred_valid);

  // R2: a call followed by a return predicts the call's return address
  p_push_pop_r2: assert property (@(posedge clk) disable iff (rst)
    (is_ret && $past(is_call) && !$past(rst))
      |-> (pred_valid && pred_target == $past(exp_ret)));

  // R6: after a combined call and return the stack is not empty
  p_both_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (is_ret && $past(is_call && is_ret) && !$past(rst)) |-> pred_valid);

  // R7: no prediction without a return
  p_ret_gate_r7: assert property (@(posedge clk) disable iff (rst)
    !is_ret |-> !pred_valid);
endmodule

bind ras_predictor ras_predictor_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .is_call(is_call),
  .is_ret(is_ret), .half_len(half_len),
  .pred_target(pred_target), .pred_valid(pred_valid)
);

// File: tb/ras_predictor_test.sv
`timescale 1ns/1ps
module ras_predictor_test;
  localparam int AW    = 32;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] fetch_pc = '0;
  logic          is_call = 1'b0;
  logic          is_ret = 1'b0;
  logic          half_len = 1'b0;
  logic [AW-1:0] pred_target;
  logic          pred_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ras_predictor #(.AW(AW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .is_call(is_call),
    .is_ret(is_ret), .half_len(half_len),
    .pred_target(pred_target), .pred_valid(pred_valid)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one fetch cycle from a negedge, sample outputs, end at next negedge.
  task automatic op(input logic c, input logic r, input logic [AW-1:0] pc,
                    input logic h, output logic v, output logic [AW-1:0] t);
    is_call = c; is_ret = r; fetch_pc = pc; half_len = h;
    #1;
    v = pred_valid; t = pred_target;
    @(negedge clk);
    is_call = 1'b0; is_ret = 1'b0; fetch_pc = '0; half_len = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic v; logic [AW-1:0] t;
    do_reset();
    op(0, 0, '0, 0, v, t); chk("R7 idle after reset", AW'(v), 0);
    op(0, 1, '0, 0, v, t); chk("R1 pop after reset", AW'(v), 0);
  endtask

  task automatic t_lengths();
    logic v; logic [AW-1:0] t;
    do_reset();
    op(1, 0, 32'h100, 0, v, t);
    op(1, 0, 32'h200, 1, v, t);
    op(0, 0, 32'h0, 0, v, t); chk("R7 no ret nonempty", AW'(v), 0);
    op(0, 1, '0, 0, v, t); chk("R2 half valid", AW'(v), 1); chk("R2 half addr", t, 32'h202);
    op(0, 1, '0, 0, v, t); chk("R3 second valid", AW'(v), 1); chk("R2 full addr", t, 32'h104);
    op(0, 1, '0, 0, v, t); chk("R4 drained", AW'(v), 0);
  endtask

  task automatic t_empty_pop();
    logic v; logic [AW-1:0] t;
    do_reset();
    op(0, 1, '0, 0, v, t); chk("R4 empty pop 1", AW'(v), 0);
    op(0, 1, '0, 0, v, t); chk("R4 empty pop 2", AW'(v), 0);
    op(1, 0, 32'h300, 0, v, t);
    op(0, 1, '0, 0, v, t); chk("R4 push after empty valid", AW'(v), 1);
    chk("R4 push after empty addr", t, 32'h304);
    op(0, 1, '0, 0, v, t); chk("R4 empty again", AW'(v), 0);
  endtask

  task automatic t_overflow();
    logic v; logic [AW-1:0] t;
    do_reset();
    for (int i = 0; i < DEPTH + 2; i++) op(1, 0, 32'h1000 + AW'(16 * i), 0, v, t);
    for (int i = DEPTH + 1; i >= 2; i--) begin
      op(0, 1, '0, 0, v, t);
      chk("R5 overflow valid", AW'(v), 1);
      chk("R5 overflow order", t, 32'h1004 + AW'(16 * i));
    end
    op(0, 1, '0, 0, v, t); chk("R5 oldest lost", AW'(v), 0);
  endtask

  task automatic t_both();
    logic v; logic [AW-1:0] t;
    do_reset();
    op(1, 0, 32'h400, 0, v, t);
    op(1, 0, 32'h500, 0, v, t);
    op(1, 1, 32'h600, 0, v, t);
    chk("R6 both valid", AW'(v), 1); chk("R6 both predicts old top", t, 32'h504);
    op(0, 1, '0, 0, v, t); chk("R6 replaced top", t, 32'h604);
    op(0, 1, '0, 0, v, t); chk("R6 below kept", t, 32'h404);
    op(0, 1, '0, 0, v, t); chk("R6 depth unchanged", AW'(v), 0);
    op(1, 1, 32'h700, 1, v, t); chk("R6 both on empty", AW'(v), 0);
    op(0, 1, '0, 0, v, t); chk("R6 empty then push valid", AW'(v), 1);
    chk("R6 empty then push addr", t, 32'h702);
    op(0, 1, '0, 0, v, t); chk("R6 single entry", AW'(v), 0);
  endtask

  task automatic t_wrap_and_midreset();
    logic v; logic [AW-1:0] t;
    do_reset();
    op(1, 0, 32'hFFFF_FFFE, 0, v, t);
    op(0, 1, '0, 0, v, t); chk("R8 wrap addr", t, 32'h0000_0002);
    op(1, 0, 32'h800, 0, v, t);
    op(1, 0, 32'h900, 0, v, t);
    do_reset();
    op(0, 1, '0, 0, v, t); chk("R1 reset clears entries", AW'(v), 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_lengths();
    t_empty_pop();
    t_overflow();
    t_both();
    t_wrap_and_midreset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule